// File: doc/BRIEF.md
# Buffered Interval Timer

This block is a 16-bit interval timer. Its counter advances once per count strobe. The strobe comes either from a prescaled version of the system clock or from rising edges of an external event input. Software writes a compare value and a control byte through a single write port. On the first strobe after the timer is started, the counter leaves its idle value FFFFH for 0000H, the output toggles, and the compare value is copied into an internal buffer. From then on the counter is compared against that buffer rather than against the software register.

When the counter equals the buffered value, the next strobe clears the counter to zero, toggles the output and raises a one-cycle match interrupt. The buffer is reloaded from the software register at that same point. A new compare value written while the timer runs therefore takes effect only from the following period. A period lasts (compare + 1) count strobes.

The control byte holds four fields: an enable bit (bit 0), a source select (bit 1, 1 = external event), a 3-bit prescaler select (bits 4:2) and a 3-bit mode field (bits 7:5). Only mode 000, interval mode, makes the timer run.

Top module: `ivt_top`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), count is FFFFH, tmr_out is 0 and match_irq is 0.
- R2: While the timer is not running, count stays at FFFFH and tmr_out stays at 0.
- R3: The first count strobe after the timer starts sets count to 0000H, inverts tmr_out, copies the compare register into the buffer, and raises no interrupt.
- R4: A count strobe that finds count equal to the buffer clears count to 0000H, inverts tmr_out, and drives match_irq high for the following clock cycle.
- R5: Once running, match_irq pulses every (compare + 1) count strobes.
- R6: Prescaler select n (control bits 4:2) gives one count strobe every 2^n clocks. With an internal source, the first counter move comes 2^n clock edges after the edge that latches the enable.
- R7: With control bit 1 set, each rising edge of evt_in produces exactly one count strobe and the prescaler has no effect. The counter moves on the second clock edge after the edge that first samples evt_in high.
- R8: A mode field (control bits 7:5) other than 000 keeps the timer stopped even with enable set.
- R9: A compare value of 0000H gives a match, a toggle and an interrupt on every count strobe.
- R10: A compare value written while running does not change the current period. It applies from the next match onward.
- R11: Clearing the enable bit returns count to FFFFH, tmr_out to 0 and match_irq to 0 on the next clock edge.
- R12: A write with wr_en high stores wr_data in the compare register when wr_sel is 1, and its low byte in the control register when wr_sel is 0. A compare write never changes the control state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control byte, 1 compare value |
| wr_data | input | 16 | Write data |
| evt_in | input | 1 | External event input (asynchronous) |
| count | output | 16 | Current counter value |
| tmr_out | output | 1 | Toggle output |
| match_irq | output | 1 | One-cycle compare-match interrupt |

## Verification
A register write is latched on the clock edge where wr_en is sampled. The counter first moves 2^n edges later with an internal source. With an external source, it moves two edges after evt_in is first sampled high. Count, tmr_out and match_irq all change together on the edge that consumes a count strobe. A behavioural reference model in the bench advances on every rising edge, and the outputs are compared with it on every falling edge. The directed checks count falling edges from the end of each write, so every expected value is sampled in the exact cycle it falls due.

// File: rtl/ivt_pkg.sv
// Package: shared types and constants for the buffered interval timer.
// Assumes the control byte occupies the low 8 bits of a register write.
package ivt_pkg;

    localparam int CTRL_W = 8;

    // Control byte layout, MSB first: mode, prescaler select, source select, enable
    typedef struct packed {
        logic [2:0] mode;
        logic [2:0] cks;
        logic       ext_sel;
        logic       enable;
    } ctrl_t;

    localparam logic [2:0] MODE_INTERVAL = 3'b000;
    localparam logic       WSEL_CTRL     = 1'b0;
    localparam logic       WSEL_CMP      = 1'b1;

endpackage

// File: rtl/ivt_prescaler.sv
// Prescaler: produces a one-cycle count strobe every 2^cks clocks while run is high.
// Assumes the divider phase restarts from zero whenever run is low, so the
// first strobe arrives 2^cks cycles after run rises.
module ivt_prescaler #(
    parameter int CKS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CKS_W-1:0] cks,
    output logic             tick
);
    localparam int DIV_W = (1 << CKS_W) - 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // Build the low-bit mask of 2^cks - 1, one bit per divider stage
    for (genvar gi = 0; gi < DIV_W; gi++) begin : g_mask
        assign mask[gi] = (cks > CKS_W'(gi));
    end

    assign tick = run && ((div_q & mask) == mask);

    // Free-running divider phase, held at zero while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    a_r6_div1_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cks == '0) |-> tick);

endmodule

// File: rtl/ivt_event_sync.sv
// Event synchroniser: brings an asynchronous event into the clock domain
// through a flip-flop chain and emits one strobe per rising edge.
// Assumes events are held for at least one clock in each level.
module ivt_event_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic evt_in,
    output logic strobe
);
    logic [STAGES:0] sync_q;

    // Shift the raw input through the synchroniser plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-1:0], evt_in};
    end

    assign strobe = run && sync_q[STAGES-1] && !sync_q[STAGES];

    a_r7_one_strobe_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

endmodule

// File: rtl/ivt_core.sv
// Counter core: 16-bit up counter compared against a buffered compare value.
// Assumes cen is a single-cycle strobe and that run low means fully idle.
module ivt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cen,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] cnt,
    output logic             tout,
    output logic             irq
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] buf_q;
    logic             started_q;
    logic             tout_q;
    logic             irq_q;
    logic             hit;

    assign hit = started_q && (cnt_q == buf_q);

    // Start, count, match-and-reload sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '1;
            buf_q     <= '0;
            started_q <= 1'b0;
            tout_q    <= 1'b0;
            irq_q     <= 1'b0;
        end else if (!run) begin
            cnt_q     <= '1;
            started_q <= 1'b0;
            tout_q    <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            irq_q <= cen && hit;
            if (cen) begin
                if (!started_q) begin
                    cnt_q     <= '0;
                    buf_q     <= cmp_val;
                    started_q <= 1'b1;
                    tout_q    <= ~tout_q;
                end else if (hit) begin
                    cnt_q  <= '0;
                    buf_q  <= cmp_val;
                    tout_q <= ~tout_q;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt  = cnt_q;
    assign tout = tout_q;
    assign irq  = irq_q;

    a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cen && !started_q) |=> (cnt_q == '0 && !irq_q));

    a_r4_irq_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (cnt_q == '0));

    a_r4_irq_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (tout_q != $past(tout_q)));

    a_r5_within_buffer: assert property (@(posedge clk) disable iff (!rst_n)
        started_q |-> (cnt_q <= buf_q));

    a_r11_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '1 && !tout_q && !irq_q));

endmodule

// File: rtl/ivt_top.sv
// Top: register write port, run decode, count-source selection and core.
// Assumes CNT_W is at least the control byte width.
module ivt_top
    import ivt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CKS_W  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             evt_in,
    output logic [CNT_W-1:0] count,
    output logic             tmr_out,
    output logic             match_irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] cmp_q;
    logic             run;
    logic             tick;
    logic             evt_strobe;
    logic             cen;

    // Software-visible registers, written through the strobe port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel == WSEL_CMP) cmp_q  <= wr_data;
            else                    ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    assign run = ctrl_q.enable && (ctrl_q.mode == MODE_INTERVAL);
    assign cen = ctrl_q.ext_sel ? evt_strobe : tick;

    ivt_prescaler #(.CKS_W(CKS_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .cks(ctrl_q.cks), .tick(tick)
    );

    ivt_event_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .run(run), .evt_in(evt_in), .strobe(evt_strobe)
    );

    ivt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .run(run), .cen(cen), .cmp_val(cmp_q),
        .cnt(count), .tout(tmr_out), .irq(match_irq)
    );

    a_r8_mode_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.mode != MODE_INTERVAL) |=> (count == '1 && !tmr_out));

endmodule

// File: tb/ivt_top_bench.sv
module ivt_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [15:0] wr_data = '0;
    logic        evt_in = 1'b0;
    logic [15:0] count;
    logic        tmr_out;
    logic        match_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ivt_top u_ivt_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .evt_in(evt_in), .count(count), .tmr_out(tmr_out), .match_irq(match_irq)
    );

    // Behavioural reference model
    logic [7:0]  m_ctrl;
    logic [15:0] m_cmp, m_cnt, m_buf;
    logic        m_out, m_irq, m_started, model_ok = 1'b0;
    logic [2:0]  m_sync;
    int          m_phase, per;
    bit          m_run, m_tick, m_edge, m_cen;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cmp = 0; m_phase = 0; m_cnt = 16'hFFFF; m_buf = 0;
            m_out = 0; m_irq = 0; m_started = 0; m_sync = 0; model_ok = 1;
        end else begin
            m_run  = m_ctrl[0] && (m_ctrl[7:5] == 3'b000);
            per    = 1 << m_ctrl[4:2];
            m_tick = m_run && ((m_phase % per) == per - 1);
            m_edge = m_run && m_sync[1] && !m_sync[2];
            m_cen  = m_ctrl[1] ? m_edge : m_tick;
            m_phase = m_run ? (m_phase + 1) % 128 : 0;
            if (!m_run) begin
                m_cnt = 16'hFFFF; m_out = 0; m_irq = 0; m_started = 0;
            end else begin
                m_irq = 0;
                if (m_cen) begin
                    if (!m_started) begin
                        m_cnt = 0; m_buf = m_cmp; m_started = 1; m_out = !m_out;
                    end else if (m_cnt == m_buf) begin
                        m_cnt = 0; m_buf = m_cmp; m_out = !m_out; m_irq = 1;
                    end else begin
                        m_cnt = m_cnt + 16'd1;
                    end
                end
            end
            if (wr_en) begin
                if (wr_sel) m_cmp = wr_data;
                else        m_ctrl = wr_data[7:0];
            end
            m_sync = {m_sync[1:0], evt_in};
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (model_ok && rst_n && !done) begin
            chk("R5", "model count", count, m_cnt);
            chk("R3", "model tmr_out", tmr_out, m_out);
            chk("R4", "model match_irq", match_irq, m_irq);
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_fail++;
            $display("FAIL all watchdog: actual %0d expected below %0d", cyc, 100000);
            report();
        end
    end

    task automatic wr(input logic sel, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_irq();
        do @(negedge clk); while (!match_irq);
    endtask

    task automatic interval(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!match_irq);
    endtask

    task automatic pulse();
        @(negedge clk); evt_in = 1'b1;
        @(negedge clk);
        @(negedge clk); evt_in = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "reset count", count, 16'hFFFF);
        chk("R1", "reset tmr_out", tmr_out, 0);
        chk("R1", "reset match_irq", match_irq, 0);

        // R12: compare write with bit0 set must not start the timer
        wr(1'b1, 16'h0001);
        repeat (3) @(negedge clk);
        chk("R12", "count after compare-only write", count, 16'hFFFF);
        chk("R2", "tmr_out while stopped", tmr_out, 0);

        // R3 / R5: start with divide-by-1, compare 4
        wr(1'b1, 16'd4);
        wr(1'b0, 16'h0001);
        chk("R3", "count on latch edge", count, 16'hFFFF);
        @(negedge clk);
        chk("R3", "count after start", count, 16'h0000);
        chk("R3", "tmr_out after start", tmr_out, 1);
        chk("R3", "no irq at start", match_irq, 0);
        wait_irq();
        chk("R4", "count at match", count, 0);
        interval(n);
        chk("R5", "period cmp=4 div1", n, 5);

        // R11: disable
        wr(1'b0, 16'h0000);
        @(negedge clk);
        chk("R11", "count after disable", count, 16'hFFFF);
        chk("R11", "tmr_out after disable", tmr_out, 0);
        chk("R11", "irq after disable", match_irq, 0);

        // R6: divide-by-4, compare 3
        wr(1'b1, 16'd3);
        wr(1'b0, 16'h0009);
        repeat (3) @(negedge clk);
        chk("R6", "count before first strobe", count, 16'hFFFF);
        @(negedge clk);
        chk("R6", "count at first strobe", count, 16'h0000);
        wait_irq();
        interval(n);
        chk("R6", "period cmp=3 div4", n, 16);
        wr(1'b0, 16'h0000);

        // R8: nonzero mode with enable set
        wr(1'b0, 16'h0021);
        n = 0;
        repeat (20) begin @(negedge clk); if (match_irq || tmr_out) n++; end
        chk("R8", "count with mode 001", count, 16'hFFFF);
        chk("R8", "activity with mode 001", n, 0);
        wr(1'b0, 16'h0000);

        // R7: external events, prescaler select 7 ignored
        wr(1'b1, 16'd100);
        wr(1'b0, 16'h001F);
        repeat (10) @(negedge clk);
        chk("R7", "no count without events", count, 16'hFFFF);
        pulse();
        chk("R7", "count after first event", count, 0);
        repeat (3) pulse();
        chk("R7", "count after four events", count, 3);
        chk("R7", "tmr_out after four events", tmr_out, 1);
        wr(1'b0, 16'h0000);

        // R9: compare zero
        wr(1'b1, 16'd0);
        wr(1'b0, 16'h0001);
        @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R9", "irq every strobe", match_irq, 1);
            chk("R9", "toggle every strobe", tmr_out, (i % 2 == 0) ? 0 : 1);
        end
        wr(1'b0, 16'h0000);

        // R10: compare change while running
        wr(1'b1, 16'd9);
        wr(1'b0, 16'h0001);
        wait_irq();
        wr(1'b1, 16'd2);
        interval(n);
        chk("R10", "period in flight keeps old compare", n + 2, 10);
        interval(n);
        chk("R10", "next period uses new compare", n, 3);
        wr(1'b0, 16'h0000);

        repeat (4) @(negedge clk);
        report();
    end
endmodule